// File: doc/BRIEF.md
# Per-Cycle Cache Port Budget

This block counts the data-cache accesses that a load/store unit launches during one pipeline slot. The slot ends when `slot_end` is pulsed. Loads and stores draw on separate pools of ports. Each pool's size is a parameter.

A requester looks at `ld_avail` or `st_avail` and raises `ld_claim` or `st_claim` to take one port. One load claim and one store claim may be made per clock. A claim made when the pool is empty is refused: `claim_err` goes high and the count stays as it was. At the end of a slot both counts return to zero.

The block also holds a flag that says the cache has refused traffic. The cache sets this flag and clears it with a retry. The block pulses `unblock` toward the issue stage in two cases:
- a slot closes with every load port used and the cache not blocked;
- the cache sends a retry.

In either case, loads held back for lack of a port or for a busy cache may be issued again.

All pins are plain control and status signals. There is no data stream, so no valid/ready pair.

Top module: `cache_port_budget`

## Requirements
- R1: The load count and the store count are separate and sized by `LD_PORTS` and `ST_PORTS`. A load claim and a store claim in the same clock are each handled on their own.
- R2: `ld_avail` is high exactly while the load count is below `LD_PORTS`. `st_avail` is high exactly while the store count is below `ST_PORTS`.
- R3: A claim made while its kind has a free port raises that kind's count by one at the next clock edge.
- R4: A claim made while its kind has no free port drives `claim_err` high in that same clock and leaves the count unchanged.
- R5: `slot_end` sets both counts to zero at the next edge. Claims granted in the same clock count toward the slot that is closing.
- R6: `unblock` is high for one cycle, in the cycle after a `slot_end`, when the load count, including any claim granted in the `slot_end` clock, equals `LD_PORTS` and `cache_blocked` is low.
- R7: A closing slot does not raise `unblock` if the load ports were not all used, or if `cache_blocked` was high.
- R8: `block_set` raises `cache_blocked` at the next edge. `cache_retry` clears it and raises `unblock` in the next cycle. If both arrive in the same clock, the retry wins.
- R9: `takeover` clears the store count and `cache_blocked` at the next edge and leaves the load count unchanged.
- R10: While `rst_n` is low, both counts are zero, `cache_blocked` and `unblock` are low, and both avail outputs are high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| slot_end | input | 1 | Marks the last clock of a pipeline slot |
| ld_claim | input | 1 | Take one load port |
| st_claim | input | 1 | Take one store port |
| block_set | input | 1 | The cache refused a request |
| cache_retry | input | 1 | The cache can accept traffic again |
| takeover | input | 1 | Context handover: clear store count and blocked flag |
| ld_avail | output | 1 | A load port is free |
| st_avail | output | 1 | A store port is free |
| ld_used | output | CW | Load ports taken in this slot |
| st_used | output | CW | Store ports taken in this slot |
| cache_blocked | output | 1 | The cache is refusing traffic |
| unblock | output | 1 | One-cycle pulse: held loads may reissue |
| claim_err | output | 1 | A claim arrived with no free port of its kind |

## Verification
The stimulus covers these patterns:
- paired load and store claims until each pool runs out, which separates the two counts and shows a refusal leaving the count unchanged;
- slots closed with the load pool full, partly full, and full while blocked, which separate the three outcomes of the replay pulse;
- retry, block and takeover alone and together, which show which clear has priority and which count a takeover touches.

A mid-run reset checks that every count returns to its idle state.

// File: rtl/cpb_pkg.sv
package cpb_pkg;
  typedef enum logic {KIND_LD = 1'b0, KIND_ST = 1'b1} port_kind_e;

  function automatic int cnt_width(input int a, input int b);
    int m;
    m = (a > b) ? a : b;
    return (m < 1) ? 1 : $clog2(m + 1);
  endfunction
endpackage

// File: rtl/port_budget_ctr.sv
module port_budget_ctr #(
  parameter int PORTS = 2,
  parameter int CW    = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          claim,
  input  logic          clear_slot,
  input  logic          clear_aux,
  output logic [CW-1:0] used,
  output logic          avail,
  output logic          reject,
  output logic          full_after
);
  localparam logic [CW-1:0] LIMIT = CW'(PORTS);

  logic [CW-1:0] used_after;

  always_comb begin
    avail      = (used < LIMIT);
    reject     = claim && !avail;
    used_after = (claim && avail) ? used + 1'b1 : used;
    full_after = (used_after == LIMIT);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                       used <= '0;
    else if (clear_slot || clear_aux) used <= '0;
    else                              used <= used_after;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    used <= LIMIT); // R2
  AST_CLAIM_INC: assert property (@(posedge clk) disable iff (!rst_n)
    claim && avail && !clear_slot && !clear_aux |=> used == $past(used) + 1'b1); // R3
  AST_REJECT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    claim && !avail && !clear_slot && !clear_aux |=> $stable(used)); // R4
  AST_SLOT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    clear_slot |=> used == '0); // R5
endmodule

// File: rtl/cache_block_flag.sv
module cache_block_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic block_set,
  input  logic cache_retry,
  input  logic takeover,
  output logic blocked
);
  always_ff @(posedge clk) begin
    if (!rst_n)                         blocked <= 1'b0;
    else if (cache_retry || takeover)   blocked <= 1'b0;
    else if (block_set)                 blocked <= 1'b1;
  end

  AST_RETRY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cache_retry |=> !blocked); // R8
  AST_TAKEOVER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    takeover |=> !blocked); // R9
endmodule

// File: rtl/unblock_gen.sv
module unblock_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic slot_end,
  input  logic ld_full_after,
  input  logic blocked,
  input  logic cache_retry,
  output logic unblock
);
  always_ff @(posedge clk) begin
    if (!rst_n) unblock <= 1'b0;
    else        unblock <= (slot_end && ld_full_after && !blocked) || cache_retry;
  end

  AST_RETRY_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    cache_retry |=> unblock); // R8
  AST_NO_PULSE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    slot_end && blocked && !cache_retry |=> !unblock); // R7
  AST_NO_IDLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_end && !cache_retry |=> !unblock); // R6
endmodule

// File: rtl/cache_port_budget.sv
module cache_port_budget
  import cpb_pkg::*;
#(
  parameter int LD_PORTS = 2,
  parameter int ST_PORTS = 1,
  parameter int CW       = cnt_width(LD_PORTS, ST_PORTS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          slot_end,
  input  logic          ld_claim,
  input  logic          st_claim,
  input  logic          block_set,
  input  logic          cache_retry,
  input  logic          takeover,
  output logic          ld_avail,
  output logic          st_avail,
  output logic [CW-1:0] ld_used,
  output logic [CW-1:0] st_used,
  output logic          cache_blocked,
  output logic          unblock,
  output logic          claim_err
);
  localparam int NKIND = 2;

  logic [NKIND-1:0] claim_v, avail_v, reject_v, full_v, aux_v;
  logic [CW-1:0]    used_a [NKIND];

  assign claim_v[KIND_LD] = ld_claim;
  assign claim_v[KIND_ST] = st_claim;
  assign aux_v[KIND_LD]   = 1'b0;
  assign aux_v[KIND_ST]   = takeover;

  for (genvar k = 0; k < NKIND; k++) begin : g_kind
    localparam int KP = (k == int'(KIND_LD)) ? LD_PORTS : ST_PORTS;
    port_budget_ctr #(.PORTS(KP), .CW(CW)) u_ctr (
      .clk        (clk),
      .rst_n      (rst_n),
      .claim      (claim_v[k]),
      .clear_slot (slot_end),
      .clear_aux  (aux_v[k]),
      .used       (used_a[k]),
      .avail      (avail_v[k]),
      .reject     (reject_v[k]),
      .full_after (full_v[k])
    );
  end

  cache_block_flag u_flag (
    .clk         (clk),
    .rst_n       (rst_n),
    .block_set   (block_set),
    .cache_retry (cache_retry),
    .takeover    (takeover),
    .blocked     (cache_blocked)
  );

  unblock_gen u_unblk (
    .clk           (clk),
    .rst_n         (rst_n),
    .slot_end      (slot_end),
    .ld_full_after (full_v[KIND_LD]),
    .blocked       (cache_blocked),
    .cache_retry   (cache_retry),
    .unblock       (unblock)
  );

  assign ld_avail  = avail_v[KIND_LD];
  assign st_avail  = avail_v[KIND_ST];
  assign ld_used   = used_a[KIND_LD];
  assign st_used   = used_a[KIND_ST];
  assign claim_err = |reject_v;

  AST_TAKEOVER_KEEPS_LD: assert property (@(posedge clk) disable iff (!rst_n)
    takeover && !slot_end && !ld_claim |=> $stable(ld_used)); // R9
  AST_TAKEOVER_ST: assert property (@(posedge clk) disable iff (!rst_n)
    takeover |=> st_used == '0); // R9
  AST_KINDS_APART: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_claim && !slot_end |=> $stable(ld_used)); // R1
endmodule

// File: tb/cache_port_budget_tb_top.sv
module cache_port_budget_tb_top;
  localparam int CW = 2;

  logic clk = 1'b0;
  logic rst_n, slot_end, ld_claim, st_claim, block_set, cache_retry, takeover;
  logic ld_avail, st_avail, cache_blocked, unblock, claim_err;
  logic [CW-1:0] ld_used, st_used;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  cache_port_budget #(.LD_PORTS(2), .ST_PORTS(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .slot_end(slot_end), .ld_claim(ld_claim),
    .st_claim(st_claim), .block_set(block_set), .cache_retry(cache_retry),
    .takeover(takeover), .ld_avail(ld_avail), .st_avail(st_avail),
    .ld_used(ld_used), .st_used(st_used), .cache_blocked(cache_blocked),
    .unblock(unblock), .claim_err(claim_err)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Row bits: [12]ld_claim [11]st_claim [10]slot_end [9]block_set [8]retry
  // [7]takeover [6]exp claim_err [5:4]exp ld_used [3:2]exp st_used
  // [1]exp blocked [0]exp unblock. Ports: 2 load, 1 store.
  localparam int NROW = 15;
  localparam logic [12:0] VEC [NROW] = '{
    13'b1_1_0_0_0_0_0_01_01_0_0, // R1 R3 paired claims
    13'b1_1_0_0_0_0_1_10_01_0_0, // R4 store pool empty, load granted
    13'b1_0_0_0_0_0_1_10_01_0_0, // R4 load pool empty
    13'b0_0_1_0_0_0_0_00_00_0_1, // R5 R6 full slot closes
    13'b0_0_0_0_0_0_0_00_00_0_0, // R6 pulse lasts one cycle
    13'b1_0_0_1_0_0_0_01_00_1_0, // R8 block set
    13'b1_0_1_0_0_0_0_00_00_1_0, // R7 full but blocked
    13'b0_0_0_0_1_0_0_00_00_0_1, // R8 retry
    13'b1_0_1_0_0_0_0_00_00_0_0, // R7 partly used slot
    13'b0_1_0_0_0_0_0_00_01_0_0, // R3 store claim
    13'b1_0_0_0_0_1_0_01_00_0_0, // R9 takeover keeps load count
    13'b0_0_0_1_0_0_0_01_00_1_0, // R8 block
    13'b0_0_0_0_0_1_0_01_00_0_0, // R9 takeover clears blocked
    13'b0_0_0_1_1_0_0_01_00_0_1, // R8 retry wins over set
    13'b0_0_1_0_0_0_0_00_00_0_0  // R7 R5 one of two used
  };

  task automatic drive(input logic [5:0] v);
    {ld_claim, st_claim, slot_end, block_set, cache_retry, takeover} = v;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int prev_ld;
    int prev_st;
    rst_n = 1'b0;
    drive(6'b0);
    repeat (2) @(negedge clk);
    // R10 reset state
    chk("R10 ld_used", ld_used, 0);
    chk("R10 st_used", st_used, 0);
    chk("R10 blocked", cache_blocked, 0);
    chk("R10 unblock", unblock, 0);
    chk("R10 avail", {ld_avail, st_avail}, 3);
    rst_n = 1'b1;
    prev_ld = 0;
    prev_st = 0;

    for (int i = 0; i < NROW; i++) begin
      @(negedge clk);
      drive(VEC[i][12:7]);
      #2;
      chk("R2 ld_avail", ld_avail, int'(prev_ld < 2));
      chk("R2 st_avail", st_avail, int'(prev_st < 1));
      chk("R4 claim_err", claim_err, VEC[i][6]);
      @(negedge clk);
      chk("R3 ld_used", ld_used, VEC[i][5:4]);
      chk("R1 st_used", st_used, VEC[i][3:2]);
      chk("R8 blocked", cache_blocked, VEC[i][1]);
      chk("R6 unblock", unblock, VEC[i][0]);
      prev_ld = VEC[i][5:4];
      prev_st = VEC[i][3:2];
      drive(6'b0);
    end

    // R10 mid-run reset clears counts and flag
    @(negedge clk);
    drive(6'b110100);
    @(negedge clk);
    drive(6'b0);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R10 ld_used after reset", ld_used, 0);
    chk("R10 st_used after reset", st_used, 0);
    chk("R10 blocked after reset", cache_blocked, 0);
    rst_n = 1'b1;

    // R6 claim in the closing clock completes the pool
    @(negedge clk);
    drive(6'b100000);
    @(negedge clk);
    drive(6'b101000);
    @(negedge clk);
    drive(6'b0);
    chk("R6 unblock after late fill", unblock, 1);
    chk("R5 ld_used after late fill", ld_used, 0);

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule